// File: doc/BRIEF.md
# I2C Target Byte Engine with Selectable Interrupt Point

This block is the target-side byte engine of an I2C port. It runs on the system clock. SCL and SDA arrive as oversampled inputs and pass through a two-flop synchroniser and an edge detector. The block drives each line only through an open-drain pull-down enable. It recognises START and STOP. It shifts eight data bits and an acknowledge bit per byte, and raises a transfer-complete interrupt that holds SCL low until firmware clears it.

The feature that sets it apart is the interrupt point. Normally the interrupt fires after the acknowledge bit. While receiving a data byte, firmware may instead ask for it after the eighth bit. The whole byte can then be inspected before the acknowledge level is chosen, for example after a packet-error check. A first (address) byte or a transmitted byte always interrupts after the acknowledge. If firmware drops the select while serving the early interrupt, a second interrupt follows the acknowledge of the same byte.

Top module: `i2c_byte_engine`

## Requirements
- R1: SDA falling while SCL is high (START) sets `bus_busy` and `first_byte` and restarts the bit count. SDA rising while SCL is high (STOP) clears both. While `bus_busy` is low, `sda_oe` stays 0.
- R2: Each SCL rising edge of bits 1 to 8 shifts SDA into `rx_byte`, most significant bit first. After the eighth rising edge `rx_byte` holds the whole byte.
- R3: In a transmitted data byte (`ctl_tx`=1, `first_byte`=0), bit slot k (0..7) pulls SDA low exactly when `tx_byte[7-k]` is 0. SDA is released in the acknowledge slot. SDA is also released whenever `last_ack` is 1. The drive changes only while SCL is low.
- R4: In a received byte (`first_byte`=1 or `ctl_tx`=0), the acknowledge slot pulls SDA low when `ctl_ack_en`=0. When `ctl_ack_en`=1 the slot pulls SDA low if `ctl_ack_nack`=0 and releases SDA if `ctl_ack_nack`=1.
- R5: `last_ack` takes the SDA level (1 = not acknowledged) at the ninth SCL rising edge of a byte and keeps it at all other times.
- R6: `irq` sets at the SCL falling edge that ends the ninth bit in these cases: transmit, the first byte, or `ctl_early`=0.
- R7: In a received data byte with `ctl_early`=1, `irq` sets at the SCL falling edge that ends the eighth bit. It does not set again at the ninth if `ctl_early` is still 1 then.
- R8: If `ctl_early` is 0 at the falling edge that ends the ninth bit of a byte that gave an early interrupt, `irq` sets again there.
- R9: `irq` stays set until a one-cycle `irq_clr` pulse. `scl_oe` is asserted exactly while `irq` is set, which stretches SCL.
- R10: `first_byte` clears at the SCL falling edge that ends the ninth bit of the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| ctl_tx | input | 1 | 1 = transmit data bytes, 0 = receive |
| ctl_early | input | 1 | Request the interrupt after bit 8 while receiving data |
| ctl_ack_en | input | 1 | Use `ctl_ack_nack` for the acknowledge level |
| ctl_ack_nack | input | 1 | 0 = acknowledge, 1 = not acknowledge |
| irq_clr | input | 1 | Pulse that clears the interrupt |
| tx_byte | input | 8 | Byte to transmit |
| rx_byte | output | 8 | Received byte |
| irq | output | 1 | Transfer-complete interrupt |
| last_ack | output | 1 | Acknowledge level of the last ninth bit |
| first_byte | output | 1 | Current byte is the first after START |
| bus_busy | output | 1 | Bus between START and STOP |

## Verification
A change on SCL or SDA reaches the flags, `rx_byte`, `last_ack` and `irq` on the third clock edge after it: two synchroniser flops, then the state register. The SDA pull-down follows on the fourth edge. An `irq_clr` pulse lowers `irq` and `scl_oe` on the next edge. After every line change, control write or clear pulse, the bench lets six edges pass before it compares its reference model on each falling clock edge. It samples its explicit checks one nanosecond after a rising edge, so every result has landed before it is read.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int BYTE_BITS = 8;
  localparam int IDX_W     = $clog2(BYTE_BITS);
  localparam int POS_W     = $clog2(BYTE_BITS + 2);
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;
  localparam int N_LINES   = 2;

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_ev_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_eng_pkg::*;
#(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     raw,
  output line_ev_t ev
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
      prev  <= IDLE;
    end else begin
      chain <= {chain[STAGES-2:0], raw};
      prev  <= chain[STAGES-1];
    end
  end

  assign ev.lvl  = chain[STAGES-1];
  assign ev.rise = chain[STAGES-1] & ~prev;
  assign ev.fall = ~chain[STAGES-1] & prev;

  AST_RISE_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    ev.rise |-> $past(raw, STAGES)); // R2
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
  import i2c_eng_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_lvl,
  input  line_ev_t sda_ev,
  output logic     start_ev,
  output logic     stop_ev,
  output logic     busy
);
  assign start_ev = scl_lvl & sda_ev.fall;
  assign stop_ev  = scl_lvl & sda_ev.rise;

  always_ff @(posedge clk) begin
    if (rst)           busy <= 1'b0;
    else if (start_ev) busy <= 1'b1;
    else if (stop_ev)  busy <= 1'b0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> busy); // R1
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !busy); // R1
endmodule

// File: rtl/i2c_byte_core.sv
module i2c_byte_core
  import i2c_eng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  line_ev_t             scl_ev,
  input  logic                 sda_lvl,
  input  logic                 start_ev,
  input  logic                 stop_ev,
  input  logic                 busy,
  input  logic                 ctl_tx,
  input  logic                 ctl_early,
  input  logic                 ctl_ack_en,
  input  logic                 ctl_ack_nack,
  input  logic                 irq_clr,
  input  logic [BYTE_BITS-1:0] tx_byte,
  output logic [BYTE_BITS-1:0] rx_byte,
  output logic                 irq,
  output logic                 last_ack,
  output logic                 first_byte,
  output logic                 sda_oe
);
  localparam pos_t ACK_POS = pos_t'(BYTE_BITS);
  localparam pos_t END_POS = pos_t'(BYTE_BITS + 1);

  pos_t                 pos_q, slot_q;
  logic [BYTE_BITS-1:0] shift_q;
  logic                 irq_q, lack_q, first_q, oe_q;
  logic                 data_rx, early_hit, ninth_hit, irq_set, drive_nx;
  logic [IDX_W-1:0]     tx_idx;

  // Select only counts for data bytes being received.
  assign data_rx   = !first_q && !ctl_tx;
  assign early_hit = (pos_q == ACK_POS) && data_rx && ctl_early;
  assign ninth_hit = (pos_q == END_POS) && !(data_rx && ctl_early);
  assign irq_set   = busy && scl_ev.fall && !start_ev && !stop_ev && (early_hit || ninth_hit);
  assign tx_idx    = IDX_W'(BYTE_BITS - 1 - int'(slot_q));

  // slot_q moves only on SCL falling edges, so SDA is steady while SCL is high.
  always_comb begin
    drive_nx = 1'b0;
    if (busy) begin
      if (first_q || !ctl_tx) begin
        if (slot_q == ACK_POS) drive_nx = ctl_ack_en ? !ctl_ack_nack : 1'b1;
      end else if ((slot_q < ACK_POS) && !lack_q) begin
        drive_nx = !tx_byte[tx_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      slot_q  <= '0;
      shift_q <= '0;
      irq_q   <= 1'b0;
      lack_q  <= 1'b0;
      first_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= drive_nx;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (start_ev) begin
        pos_q   <= '0;
        slot_q  <= '0;
        first_q <= 1'b1;
      end else if (stop_ev) begin
        pos_q   <= '0;
        slot_q  <= '0;
        first_q <= 1'b0;
      end else if (busy) begin
        if (scl_ev.rise) begin
          if (pos_q < ACK_POS)       shift_q <= {shift_q[BYTE_BITS-2:0], sda_lvl};
          else if (pos_q == ACK_POS) lack_q  <= sda_lvl;
          if (pos_q < END_POS)       pos_q   <= pos_q + pos_t'(1);
        end
        if (scl_ev.fall) begin
          if (pos_q == END_POS) begin
            pos_q   <= '0;
            slot_q  <= '0;
            first_q <= 1'b0;
          end else begin
            slot_q <= pos_q;
          end
        end
      end
    end
  end

  assign rx_byte    = shift_q;
  assign irq        = irq_q;
  assign last_ack   = lack_q;
  assign first_byte = first_q;
  assign sda_oe     = oe_q;

  AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(scl_ev.fall)); // R6
  AST_NINTH_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) && $past(ctl_tx || first_q) |-> $past(pos_q) == END_POS); // R6
  AST_EARLY_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) && ($past(pos_q) == ACK_POS) |-> $past(ctl_early)); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    irq_q && !irq_clr |=> irq_q); // R9
  AST_SDA_STEADY: assert property (@(posedge clk) disable iff (rst)
    busy && scl_ev.lvl && $past(scl_ev.lvl) |-> $stable(oe_q)); // R3
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       ctl_tx,
  input  logic       ctl_early,
  input  logic       ctl_ack_en,
  input  logic       ctl_ack_nack,
  input  logic       irq_clr,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       irq,
  output logic       last_ack,
  output logic       first_byte,
  output logic       bus_busy
);
  logic [N_LINES-1:0] raw_lines;
  line_ev_t           ev [N_LINES];
  logic               start_ev, stop_ev, busy_w, irq_w;

  assign raw_lines[LINE_SCL] = scl_in;
  assign raw_lines[LINE_SDA] = sda_in;

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .raw (raw_lines[g]),
      .ev  (ev[g])
    );
  end

  i2c_bus_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (ev[LINE_SCL].lvl),
    .sda_ev   (ev[LINE_SDA]),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .busy     (busy_w)
  );

  i2c_byte_core u_core (
    .clk          (clk),
    .rst          (rst),
    .scl_ev       (ev[LINE_SCL]),
    .sda_lvl      (ev[LINE_SDA].lvl),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .busy         (busy_w),
    .ctl_tx       (ctl_tx),
    .ctl_early    (ctl_early),
    .ctl_ack_en   (ctl_ack_en),
    .ctl_ack_nack (ctl_ack_nack),
    .irq_clr      (irq_clr),
    .tx_byte      (tx_byte),
    .rx_byte      (rx_byte),
    .irq          (irq_w),
    .last_ack     (last_ack),
    .first_byte   (first_byte),
    .sda_oe       (sda_oe)
  );

  assign irq      = irq_w;
  assign scl_oe   = irq_w;
  assign bus_busy = busy_w;
endmodule

// File: tb/i2c_byte_engine_test.sv
module i2c_byte_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_in, sda_in, scl_oe, sda_oe;
  logic ctl_tx = 0, ctl_early = 0, ctl_ack_en = 0, ctl_ack_nack = 0, irq_clr = 0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic irq, last_ack, first_byte, bus_busy;

  assign scl_in = scl_m & ~scl_oe;
  assign sda_in = sda_m & ~sda_oe;

  i2c_byte_engine uut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_tx(ctl_tx), .ctl_early(ctl_early),
    .ctl_ack_en(ctl_ack_en), .ctl_ack_nack(ctl_ack_nack), .irq_clr(irq_clr),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .irq(irq), .last_ack(last_ack),
    .first_byte(first_byte), .bus_busy(bus_busy)
  );

  int n_chk = 0, n_fail = 0;
  bit quiet = 0, done = 0;

  // reference model state
  bit m_busy = 0, m_first = 0, m_irq = 0, m_lack = 0;
  int m_pos = 0;
  logic [7:0] m_rx = 8'h00;

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (quiet && !done) begin
      chk1("R9 irq per clock", irq, m_irq);
      chk1("R9 scl_oe per clock", scl_oe, m_irq);
      chk1("R1 bus_busy per clock", bus_busy, m_busy);
      chk1("R10 first_byte per clock", first_byte, m_first);
    end
  end

  task automatic settle();
    quiet = 0;
    repeat (6) @(posedge clk);
    #1;
    quiet = 1;
  endtask

  task automatic m_rise(input bit b);
    if (m_pos < 8) m_rx = {m_rx[6:0], b};
    else if (m_pos == 8) m_lack = b;
    if (m_pos < 9) m_pos++;
  endtask

  task automatic m_fall();
    bit elig;
    elig = !m_first && !ctl_tx;
    if (m_pos == 8) begin
      if (elig && ctl_early) m_irq = 1;
    end else if (m_pos == 9) begin
      if (!(elig && ctl_early)) m_irq = 1;
      m_pos = 0;
      m_first = 0;
    end
  endtask

  task automatic clock_bit(input bit mb, input bit exp_line, input string tag);
    sda_m = mb;
    settle();
    chk1(tag, sda_in, exp_line);
    scl_m = 1;
    m_rise(exp_line);
    settle();
    scl_m = 0;
    m_fall();
    settle();
  endtask

  task automatic start_cond();
    if (scl_m == 0) begin
      sda_m = 1;
      settle();
      scl_m = 1;
      if (m_busy) m_rise(1);
      settle();
    end
    sda_m = 0;
    m_busy = 1; m_first = 1; m_pos = 0;
    settle();
    scl_m = 0;
    m_fall();
    settle();
  endtask

  task automatic stop_cond();
    sda_m = 0;
    settle();
    scl_m = 1;
    m_rise(0);
    settle();
    sda_m = 1;
    m_busy = 0; m_first = 0; m_pos = 0;
    settle();
  endtask

  task automatic send_rx(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) clock_bit(d[i], d[i], "R2 master data on line");
  endtask

  task automatic recv_tx(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) clock_bit(1'b1, d[i], "R3 target drives data bit");
  endtask

  task automatic clear_irq();
    quiet = 0;
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
    m_irq = 0;
    settle();
  endtask

  task automatic finish_run();
    done = 1;
    quiet = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    settle();
    // reset state
    chk1("R9 reset irq", irq, 0);
    chk1("R9 reset scl_oe", scl_oe, 0);
    chk1("R1 reset sda_oe", sda_oe, 0);
    chk1("R1 reset bus_busy", bus_busy, 0);
    chk1("R10 reset first_byte", first_byte, 0);
    chk1("R5 reset last_ack", last_ack, 0);

    // first byte with early select set: interrupt only after the ack
    ctl_early = 1;
    start_cond();
    chk1("R1 START busy", bus_busy, 1);
    chk1("R1 START first", first_byte, 1);
    send_rx(8'hA6);
    chk1("R7 no early irq on first byte", irq, 0);
    chk8("R2 address byte", rx_byte, m_rx);
    clock_bit(1'b1, 1'b0, "R4 default ack on first byte");
    chk1("R6 ninth irq first byte", irq, 1);
    chk1("R10 first cleared", first_byte, 0);
    chk1("R5 ack sampled", last_ack, 0);
    repeat (20) @(posedge clk);
    #1;
    chk1("R9 irq held", irq, 1);
    chk1("R9 stretch held", scl_oe, 1);
    clear_irq();
    chk1("R9 cleared", irq, 0);

    // data byte, early irq, software NACK, select kept
    send_rx(8'h3C);
    chk1("R7 early irq", irq, 1);
    chk8("R2 byte at early irq", rx_byte, 8'h3C);
    chk1("R5 unchanged before ninth", last_ack, 0);
    ctl_ack_en = 1; ctl_ack_nack = 1;
    clear_irq();
    clock_bit(1'b1, 1'b1, "R4 software nack");
    chk1("R7 no ninth irq", irq, 0);
    chk1("R5 nack captured", last_ack, 1);

    // data byte, early irq, select dropped -> second irq
    send_rx(8'h81);
    chk1("R7 early irq again", irq, 1);
    ctl_ack_nack = 0; ctl_early = 0;
    clear_irq();
    clock_bit(1'b1, 1'b0, "R4 software ack");
    chk1("R8 second irq", irq, 1);
    chk1("R5 ack captured", last_ack, 0);
    chk8("R2 byte kept", rx_byte, 8'h81);
    clear_irq();

    // select clear: ninth only
    ctl_ack_en = 0;
    send_rx(8'h55);
    chk1("R6 no irq at eighth", irq, 0);
    clock_bit(1'b1, 1'b0, "R4 default ack");
    chk1("R6 ninth irq", irq, 1);
    chk8("R2 byte 55", rx_byte, 8'h55);
    ctl_tx = 1; tx_byte = 8'hC9; ctl_early = 1;
    clear_irq();

    // transmit byte, master NACK
    recv_tx(8'hC9);
    chk1("R7 select ignored in transmit", irq, 0);
    clock_bit(1'b1, 1'b1, "R3 ack slot released");
    chk1("R6 ninth irq transmit", irq, 1);
    chk1("R5 master nack", last_ack, 1);
    chk1("R3 released after nack", sda_oe, 0);
    clear_irq();

    stop_cond();
    chk1("R1 STOP idle", bus_busy, 0);
    chk1("R1 idle no drive", sda_oe, 0);
    ctl_tx = 0; ctl_early = 0;

    // repeated START mid byte
    start_cond();
    clock_bit(1'b1, 1'b1, "R2 partial bit");
    clock_bit(1'b0, 1'b0, "R2 partial bit");
    clock_bit(1'b1, 1'b1, "R2 partial bit");
    start_cond();
    chk1("R1 repeated START first", first_byte, 1);
    send_rx(8'h5A);
    chk1("R6 no irq before ack", irq, 0);
    clock_bit(1'b1, 1'b0, "R4 ack after repeated START");
    chk1("R6 irq after repeated START", irq, 1);
    chk8("R2 byte after repeated START", rx_byte, 8'h5A);
    clear_irq();
    stop_cond();
    chk1("R1 final idle", bus_busy, 0);

    finish_run();
  end
endmodule